// File: doc/BRIEF.md
# Interrupt Exception Bus Sequencer

This block runs the bus side of taking an interrupt on a 16-bit processor with an asynchronous, strobe-and-acknowledge bus. It watches a 3-bit encoded request level and compares it with the interrupt mask. It waits through one further instruction boundary, then plays out a fixed series of idle gaps and bus cycles. That series stacks the status word and the return address, runs an interrupt-acknowledge cycle, reads the handler address from the vector table and fills the two-word prefetch queue at the handler.

The surrounding core reports instruction boundaries with a one-clock pulse and supplies the live status bits, return address and supervisor stack pointer. The block drives the address, function code, strobes, read/write and write data. Every bus cycle is lengthened for as long as the acknowledge is held back. An acknowledge cycle answered on the valid-peripheral-address input falls back to an automatic vector. That cycle then follows a slow synchronous-peripheral handshake that is timed against an internal E clock.

Top module: `irq_bus_sequencer`

## Requirements
- R1: After reset `phase_o` is 0 (running), `as_o`, `ds_o` and `seq_done_o` are low and `mask_o` is 7.
- R2: At a boundary a level L is eligible only when L is not 0 and L > `mask_o`, or when L is 7 and has newly risen to 7 (R12). A mask write (`mask_wr_i`) loads `mask_o` while the block is running.
- R3: A sequence starts only at an instruction boundary where the level is eligible and where the previous boundary also found an eligible level. Consequently one whole instruction completes after the request is first seen. Boundary pulses during a sequence have no effect.
- R4: The phase codes run 1 idle(6), 2 status write, 3 acknowledge, 4 idle(4), 5 return-low write, 6 return-high write, 7 vector-high read, 8 vector-low read, 9 prefetch, 10 idle(2), 11 prefetch, then back to 0. With zero wait states the sequence lasts 44 clocks, and `seq_done_o` pulses in its last clock.
- R5: Each bus cycle takes 4 clocks: one clock with the address valid and `as_o` low, then `as_o` high for 3 clocks. There are exactly 5 reads (`rw_o`=1) and 3 writes (`rw_o`=0).
- R6: `dtack_i` is sampled in the third clock of a cycle. Each clock it is absent there adds one clock to that cycle.
- R7: The acknowledge cycle drives `fc_o`=7, the accepted level on `addr_o[3:1]`, ones on `addr_o[23:4]` and 0 on bit 0. On `dtack_i` the vector number is `din_i[7:0]`.
- R8: If `vpa_i` answers the acknowledge cycle without `dtack_i`, the data bus is ignored and the vector is 24 + level. That cycle lasts 9 to 18 clocks and ends in the clock in which `eclk_o` falls. `eclk_o` has period 10 and is high for 4 clocks.
- R9: Writes use `fc_o`=5. The status word goes to SSP-6, with bits 10:8 holding the mask from before acceptance and the other bits taken from `status_i` (bits 15:11 from `status_i[12:8]`). The return-address low word goes to SSP-2, and {8'h00, PC[23:16]} goes to SSP-4.
- R10: The vector reads use `fc_o`=5 at vector×4 and vector×4+2. The handler address is {high word[7:0], low word} and appears on `handler_o`. The prefetches use `fc_o`=6 at the handler and at the handler+2.
- R11: From the first clock of a sequence, `mask_o` equals the accepted level. Mask writes during a sequence are ignored.
- R12: A level-7 request that has been taken is not taken again until the level has left 7 and returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_level_i | input | 3 | Encoded request level, 0 = none |
| insn_done_i | input | 1 | One-clock pulse at each instruction boundary |
| mask_wr_i | input | 1 | Load the mask from `mask_wdata_i` |
| mask_wdata_i | input | 3 | New mask value |
| status_i | input | 13 | Status bits other than the mask |
| pc_i | input | 24 | Return address |
| ssp_i | input | 24 | Supervisor stack pointer |
| din_i | input | 16 | Read data |
| dtack_i | input | 1 | Data acknowledge, active high, synchronous |
| vpa_i | input | 1 | Valid peripheral address, active high, synchronous |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| rw_o | output | 1 | 1 = read, 0 = write |
| fc_o | output | 3 | Function code |
| addr_o | output | 24 | Byte address |
| dout_o | output | 16 | Write data |
| eclk_o | output | 1 | Slow peripheral E clock |
| phase_o | output | 4 | Current phase code (R4) |
| mask_o | output | 3 | Current interrupt mask |
| handler_o | output | 24 | Handler address of the last sequence |
| seq_done_o | output | 1 | Pulse in the last clock of a sequence |

## Verification
The properties assume that `dtack_i` and `vpa_i` are already synchronous to `clk`, that `insn_done_i` is a single-clock pulse, and that `din_i` is valid in the clock in which the acknowledge is sampled. The bench drives every input at the falling edge. Its bus responder raises the chosen acknowledge a set number of clocks after `as_o` rises and clears it as soon as `as_o` falls, so no acknowledge carries over into the next cycle. It raises `vpa_i` only on cycles with function code 7.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;

    localparam logic [2:0] FC_SUP_DATA = 3'd5;
    localparam logic [2:0] FC_SUP_PROG = 3'd6;
    localparam logic [2:0] FC_CPU      = 3'd7;

    localparam logic [VEC_W-1:0] AUTOVEC_BASE = 8'd24;

    localparam int GAP_ENTRY = 6;
    localparam int GAP_MID   = 4;
    localparam int GAP_PF    = 2;

    typedef enum logic [3:0] {
        PH_RUN   = 4'd0,
        PH_GAP6  = 4'd1,
        PH_WRSR  = 4'd2,
        PH_IACK  = 4'd3,
        PH_GAP4  = 4'd4,
        PH_WRPCL = 4'd5,
        PH_WRPCH = 4'd6,
        PH_RDVH  = 4'd7,
        PH_RDVL  = 4'd8,
        PH_PF1   = 4'd9,
        PH_GAP2  = 4'd10,
        PH_PF2   = 4'd11
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [2:0]        fc;
        logic              rd;
        logic              iack;
        logic [DATA_W-1:0] wdata;
    } busop_t;

endpackage

// File: rtl/irq_seq_eclk.sv
module irq_seq_eclk #(
    parameter int PERIOD = 10,
    parameter int HIGH   = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic eclk_o,
    output logic pre_rise_o,
    output logic last_high_o
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign eclk_o      = (cnt_q >= CW'(PERIOD - HIGH));
    assign pre_rise_o  = (cnt_q == CW'(PERIOD - HIGH - 1));
    assign last_high_o = (cnt_q == CW'(PERIOD - 1));
endmodule

// File: rtl/irq_seq_accept.sv
module irq_seq_accept
    import irq_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             boundary_i,
    input  logic             busy_i,
    output logic             take_o
);
    localparam logic [LVL_W-1:0] TOP = '1;

    typedef struct packed {
        logic             armed;
        logic             top_pend;
        logic [LVL_W-1:0] prev;
    } acc_t;

    acc_t d, q;
    logic top_edge, top_now, eligible, take;

    always_comb begin
        d        = q;
        top_edge = (level_i == TOP) && (q.prev != TOP);
        top_now  = q.top_pend || top_edge;
        eligible = (level_i != '0) &&
                   ((level_i > mask_i) || ((level_i == TOP) && top_now));
        take     = boundary_i && !busy_i && q.armed && eligible;

        d.prev     = level_i;
        d.top_pend = (level_i == TOP) && top_now && !take;
        if (boundary_i && !busy_i) begin
            d.armed = eligible && !take;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign take_o = take;
endmodule

// File: rtl/irq_seq_buscyc.sv
module irq_seq_buscyc
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  busop_t            op_i,
    input  logic              dtack_i,
    input  logic              vpa_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              e_pre_rise_i,
    input  logic              e_last_high_i,
    output logic              as_o,
    output logic              ds_o,
    output logic              rw_o,
    output logic [2:0]        fc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              fin_o,
    output logic              auto_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef enum logic [2:0] {
        B_ADDR, B_STRB, B_WAIT, B_DONE, B_VSYNC, B_VHIGH, B_VEND
    } bst_e;

    typedef struct packed {
        bst_e              st;
        logic [DATA_W-1:0] rdata;
    } bus_t;

    bus_t d, q;

    always_comb begin
        d      = q;
        as_o   = 1'b0;
        ds_o   = 1'b0;
        fin_o  = 1'b0;
        auto_o = 1'b0;
        if (!req_i) begin
            d.st = B_ADDR;
        end else begin
            unique case (q.st)
                B_ADDR:  d.st = B_STRB;
                B_STRB: begin
                    as_o = 1'b1;
                    ds_o = op_i.rd;
                    d.st = B_WAIT;
                end
                B_WAIT: begin
                    as_o = 1'b1;
                    ds_o = 1'b1;
                    if (dtack_i) begin
                        d.rdata = din_i;
                        d.st    = B_DONE;
                    end else if (op_i.iack && vpa_i) begin
                        d.st = B_VSYNC;
                    end
                end
                B_DONE: begin
                    as_o  = 1'b1;
                    ds_o  = 1'b1;
                    fin_o = 1'b1;
                    d.st  = B_ADDR;
                end
                B_VSYNC: begin
                    as_o = 1'b1;
                    ds_o = 1'b1;
                    if (e_pre_rise_i) d.st = B_VHIGH;
                end
                B_VHIGH: begin
                    as_o = 1'b1;
                    ds_o = 1'b1;
                    if (e_last_high_i) d.st = B_VEND;
                end
                B_VEND: begin
                    as_o   = 1'b1;
                    ds_o   = 1'b1;
                    fin_o  = 1'b1;
                    auto_o = 1'b1;
                    d.st   = B_ADDR;
                end
                default: d.st = B_ADDR;
            endcase
        end
        rw_o   = req_i ? op_i.rd : 1'b1;
        fc_o   = req_i ? op_i.fc : 3'd0;
        addr_o = req_i ? op_i.addr : '0;
        dout_o = (req_i && !op_i.rd) ? op_i.wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= B_ADDR;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata_o = q.rdata;
endmodule

// File: rtl/irq_bus_sequencer.sv
module irq_bus_sequencer
    import irq_seq_pkg::*;
#(
    parameter int E_PERIOD = 10,
    parameter int E_HIGH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  irq_level_i,
    input  logic              insn_done_i,
    input  logic              mask_wr_i,
    input  logic [LVL_W-1:0]  mask_wdata_i,
    input  logic [12:0]       status_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] ssp_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              dtack_i,
    input  logic              vpa_i,
    output logic              as_o,
    output logic              ds_o,
    output logic              rw_o,
    output logic [2:0]        fc_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              eclk_o,
    output logic [3:0]        phase_o,
    output logic [LVL_W-1:0]  mask_o,
    output logic [ADDR_W-1:0] handler_o,
    output logic              seq_done_o
);
    localparam int GW = $clog2(GAP_ENTRY);

    typedef struct packed {
        phase_e            ph;
        logic [GW-1:0]     gap;
        logic [LVL_W-1:0]  lvl;
        logic [LVL_W-1:0]  mask;
        logic [LVL_W-1:0]  old_mask;
        logic [VEC_W-1:0]  vec;
        logic [7:0]        vhi;
        logic [ADDR_W-1:0] handler;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ssp;
        logic [12:0]       sr;
    } seq_t;

    seq_t d, q;

    logic              take;
    logic              bus_req;
    busop_t            op;
    logic              bus_fin;
    logic              bus_auto;
    logic [DATA_W-1:0] bus_rdata;
    logic              e_pre_rise;
    logic              e_last_high;
    logic              done;
    logic [ADDR_W-1:0] vec_addr;

    irq_seq_eclk #(.PERIOD(E_PERIOD), .HIGH(E_HIGH)) u_eclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .eclk_o     (eclk_o),
        .pre_rise_o (e_pre_rise),
        .last_high_o(e_last_high)
    );

    irq_seq_accept u_accept (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (irq_level_i),
        .mask_i    (q.mask),
        .boundary_i(insn_done_i),
        .busy_i    (q.ph != PH_RUN),
        .take_o    (take)
    );

    irq_seq_buscyc u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (bus_req),
        .op_i         (op),
        .dtack_i      (dtack_i),
        .vpa_i        (vpa_i),
        .din_i        (din_i),
        .e_pre_rise_i (e_pre_rise),
        .e_last_high_i(e_last_high),
        .as_o         (as_o),
        .ds_o         (ds_o),
        .rw_o         (rw_o),
        .fc_o         (fc_o),
        .addr_o       (addr_o),
        .dout_o       (dout_o),
        .fin_o        (bus_fin),
        .auto_o       (bus_auto),
        .rdata_o      (bus_rdata)
    );

    always_comb begin
        d        = q;
        bus_req  = 1'b0;
        done     = 1'b0;
        op       = '0;
        op.rd    = 1'b1;
        vec_addr = {{(ADDR_W-VEC_W-2){1'b0}}, q.vec, 2'b00};

        unique case (q.ph)
            PH_RUN: begin
                if (take) begin
                    d.ph       = PH_GAP6;
                    d.gap      = '0;
                    d.lvl      = irq_level_i;
                    d.old_mask = q.mask;
                    d.mask     = irq_level_i;
                    d.pc       = pc_i;
                    d.ssp      = ssp_i;
                    d.sr       = status_i;
                end else if (mask_wr_i) begin
                    d.mask = mask_wdata_i;
                end
            end
            PH_GAP6: begin
                if (q.gap == GW'(GAP_ENTRY - 1)) begin
                    d.ph  = PH_WRSR;
                    d.gap = '0;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            PH_WRSR: begin
                bus_req  = 1'b1;
                op.addr  = q.ssp - ADDR_W'(6);
                op.fc    = FC_SUP_DATA;
                op.rd    = 1'b0;
                op.wdata = {q.sr[12:8], q.old_mask, q.sr[7:0]};
                if (bus_fin) d.ph = PH_IACK;
            end
            PH_IACK: begin
                bus_req = 1'b1;
                op.addr = {{(ADDR_W-LVL_W-1){1'b1}}, q.lvl, 1'b0};
                op.fc   = FC_CPU;
                op.iack = 1'b1;
                if (bus_fin) begin
                    d.vec = bus_auto ? (AUTOVEC_BASE + VEC_W'(q.lvl))
                                     : bus_rdata[VEC_W-1:0];
                    d.ph  = PH_GAP4;
                    d.gap = '0;
                end
            end
            PH_GAP4: begin
                if (q.gap == GW'(GAP_MID - 1)) begin
                    d.ph  = PH_WRPCL;
                    d.gap = '0;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            PH_WRPCL: begin
                bus_req  = 1'b1;
                op.addr  = q.ssp - ADDR_W'(2);
                op.fc    = FC_SUP_DATA;
                op.rd    = 1'b0;
                op.wdata = q.pc[15:0];
                if (bus_fin) d.ph = PH_WRPCH;
            end
            PH_WRPCH: begin
                bus_req  = 1'b1;
                op.addr  = q.ssp - ADDR_W'(4);
                op.fc    = FC_SUP_DATA;
                op.rd    = 1'b0;
                op.wdata = {{(2*DATA_W-ADDR_W){1'b0}}, q.pc[ADDR_W-1:DATA_W]};
                if (bus_fin) d.ph = PH_RDVH;
            end
            PH_RDVH: begin
                bus_req = 1'b1;
                op.addr = vec_addr;
                op.fc   = FC_SUP_DATA;
                if (bus_fin) begin
                    d.vhi = bus_rdata[7:0];
                    d.ph  = PH_RDVL;
                end
            end
            PH_RDVL: begin
                bus_req = 1'b1;
                op.addr = vec_addr + ADDR_W'(2);
                op.fc   = FC_SUP_DATA;
                if (bus_fin) begin
                    d.handler = {q.vhi, bus_rdata};
                    d.ph      = PH_PF1;
                end
            end
            PH_PF1: begin
                bus_req = 1'b1;
                op.addr = q.handler;
                op.fc   = FC_SUP_PROG;
                if (bus_fin) begin
                    d.ph  = PH_GAP2;
                    d.gap = '0;
                end
            end
            PH_GAP2: begin
                if (q.gap == GW'(GAP_PF - 1)) begin
                    d.ph  = PH_PF2;
                    d.gap = '0;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            PH_PF2: begin
                bus_req = 1'b1;
                op.addr = q.handler + ADDR_W'(2);
                op.fc   = FC_SUP_PROG;
                if (bus_fin) begin
                    done = 1'b1;
                    d.ph = PH_RUN;
                end
            end
            default: d.ph = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_RUN;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    assign phase_o    = q.ph;
    assign mask_o     = q.mask;
    assign handler_o  = q.handler;
    assign seq_done_o = done;
endmodule

// File: rtl/irq_bus_sequencer_chk.sv
module irq_bus_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] phase,
    input logic       as,
    input logic       ds,
    input logic       rw,
    input logic [2:0] fc,
    input logic [2:0] addr_lvl,
    input logic [2:0] mask,
    input logic [2:0] level,
    input logic       insn_done,
    input logic       eclk,
    input logic       bus_fin,
    input logic       bus_auto
);
    // R5: a data strobe never appears without the address strobe
    a_r5_ds_within_as: assert property (@(posedge clk) disable iff (!rst_n)
        ds |-> as);

    // R1: no bus activity while the core is running
    a_r1_quiet_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd0) |-> (!as && !ds));

    // R4: idle gaps carry no strobes
    a_r4_gaps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd1 || phase == 4'd4 || phase == 4'd10) |-> (!as && !ds));

    // R9: writes only in the three stacking steps
    a_r9_writes_in_stack_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (as && !rw) |-> (phase == 4'd2 || phase == 4'd5 || phase == 4'd6));

    // R7: acknowledge cycle presents CPU space and the accepted level
    a_r7_iack_code: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd3 && as) |-> (fc == 3'd7 && addr_lvl == mask));

    // R3: a sequence begins only on an instruction boundary
    a_r3_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd1 && $past(phase) == 4'd0) |-> $past(insn_done));

    // R11: mask equals the level sampled at acceptance
    a_r11_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd1 && $past(phase) == 4'd0) |-> (mask == $past(level)));

    // R8: an autovector acknowledge ends in the clock the E clock falls
    a_r8_autovec_on_e_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fin && bus_auto) |-> $fell(eclk));
endmodule

bind irq_bus_sequencer irq_bus_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_o),
    .as       (as_o),
    .ds       (ds_o),
    .rw       (rw_o),
    .fc       (fc_o),
    .addr_lvl (addr_o[3:1]),
    .mask     (mask_o),
    .level    (irq_level_i),
    .insn_done(insn_done_i),
    .eclk     (eclk_o),
    .bus_fin  (bus_fin),
    .bus_auto (bus_auto)
);

// File: tb/irq_bus_sequencer_tb.sv
module irq_bus_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_level = '0;
    logic        insn_done = 1'b0;
    logic        mask_wr = 1'b0;
    logic [2:0]  mask_wdata = '0;
    logic [12:0] status = 13'h1A5C;
    logic [23:0] pc = 24'h12_3456;
    logic [23:0] ssp = 24'h00_8000;
    logic [15:0] din;
    logic        dtack = 1'b0;
    logic        vpa = 1'b0;
    logic        as_w, ds_w, rw_w, eclk_w, done_w;
    logic [2:0]  fc_w, mask_w;
    logic [23:0] addr_w, handler_w;
    logic [15:0] dout_w;
    logic [3:0]  phase_w;

    int checks = 0;
    int fails  = 0;
    int waits_cfg = 0;
    bit use_vpa = 1'b0;
    logic [7:0] vec_num = 8'h40;
    logic [2:0] mdl_mask = 3'd7;
    int last_iack_as = 0;

    typedef struct {
        logic [3:0]  ph;
        logic        rd;
        logic [23:0] a;
        logic [2:0]  fc;
        logic [15:0] wd;
        int          alen;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    irq_bus_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .irq_level_i(irq_level), .insn_done_i(insn_done),
        .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata), .status_i(status),
        .pc_i(pc), .ssp_i(ssp), .din_i(din), .dtack_i(dtack), .vpa_i(vpa),
        .as_o(as_w), .ds_o(ds_w), .rw_o(rw_w), .fc_o(fc_w), .addr_o(addr_w),
        .dout_o(dout_w), .eclk_o(eclk_w), .phase_o(phase_w), .mask_o(mask_w),
        .handler_o(handler_w), .seq_done_o(done_w)
    );

    function automatic logic [15:0] mem_word(input logic [23:0] a);
        return a[15:0] ^ 16'h3C96;
    endfunction

    assign din = (fc_w == 3'd7) ? (use_vpa ? 16'hBEEF : {8'h00, vec_num})
                                : mem_word(addr_w);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bus responder
    int k = 0;
    always @(negedge clk) begin
        if (!as_w) begin
            k = 0; dtack <= 1'b0; vpa <= 1'b0;
        end else begin
            if (fc_w == 3'd7 && use_vpa) vpa <= (k >= 1);
            else                         dtack <= (k >= 1 + waits_cfg);
            k++;
        end
    end

    // monitor: pops expected bus operations
    bit   as_prev = 1'b0;
    int   alen = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (as_w && !as_prev) begin
                alen = 1;
                if (sb.size() == 0) begin
                    chk(1'b0, "R5", "unexpected bus cycle addr", addr_w, 0);
                end else begin
                    cur = sb.pop_front();
                    chk(phase_w == cur.ph, cur.req, "phase", phase_w, cur.ph);
                    chk(rw_w == cur.rd, cur.req, "rw", rw_w, cur.rd);
                    chk(addr_w == cur.a, cur.req, "addr", addr_w, cur.a);
                    chk(fc_w == cur.fc, cur.req, "fc", fc_w, cur.fc);
                    if (!cur.rd) chk(dout_w == cur.wd, cur.req, "wdata", dout_w, cur.wd);
                end
            end else if (as_w) begin
                alen++;
            end else if (as_prev) begin
                if (cur.alen < 0) begin
                    last_iack_as = alen;
                    chk(alen >= 8 && alen <= 17, "R8", "autovector strobe clocks", alen, 8);
                end else begin
                    chk(alen == cur.alen, "R6", "strobe clocks", alen, cur.alen);
                end
            end
        end
        as_prev = as_w;
    end

    task automatic push(input logic [3:0] ph, input logic rd, input logic [23:0] a,
                        input logic [2:0] fc, input logic [15:0] wd, input int al,
                        input string req);
        exp_t e;
        e.ph = ph; e.rd = rd; e.a = a; e.fc = fc; e.wd = wd; e.alen = al; e.req = req;
        sb.push_back(e);
    endtask

    task automatic boundary();
        @(negedge clk) insn_done = 1'b1;
        @(negedge clk) insn_done = 1'b0;
    endtask

    task automatic write_mask(input logic [2:0] m);
        @(negedge clk) begin mask_wr = 1'b1; mask_wdata = m; end
        @(negedge clk) mask_wr = 1'b0;
    endtask

    task automatic take_irq(input logic [2:0] lvl, input int w, input bit av,
                            input logic [7:0] vn);
        logic [7:0]  v;
        logic [23:0] va, hnd;
        int al, total, expt;
        v   = av ? (8'd24 + {5'd0, lvl}) : vn;
        va  = {14'd0, v, 2'b00};
        hnd = {mem_word(va)[7:0], mem_word(va + 24'd2)};
        al  = 3 + w;
        waits_cfg = w; use_vpa = av; vec_num = vn;
        push(4'd2, 1'b0, ssp - 24'd6, 3'd5, {status[12:8], mdl_mask, status[7:0]}, al, "R9");
        push(4'd3, 1'b1, {20'hFFFFF, lvl, 1'b0}, 3'd7, 16'h0, av ? -1 : al, "R7");
        push(4'd5, 1'b0, ssp - 24'd2, 3'd5, pc[15:0], al, "R9");
        push(4'd6, 1'b0, ssp - 24'd4, 3'd5, {8'h00, pc[23:16]}, al, "R9");
        push(4'd7, 1'b1, va, 3'd5, 16'h0, al, "R10");
        push(4'd8, 1'b1, va + 24'd2, 3'd5, 16'h0, al, "R10");
        push(4'd9, 1'b1, hnd, 3'd6, 16'h0, al, "R10");
        push(4'd11, 1'b1, hnd + 24'd2, 3'd6, 16'h0, al, "R10");
        irq_level = lvl;
        boundary();
        chk(phase_w == 4'd0, "R3", "no start at first boundary", phase_w, 0);
        boundary();
        chk(phase_w == 4'd1, "R3", "start at second boundary", phase_w, 1);
        total = 1;
        while (1) begin
            @(negedge clk);
            insn_done = (total == 10);
            mask_wr   = (total == 12);
            mask_wdata = 3'd0;
            if (phase_w == 4'd0) break;
            total++;
            if (total == 44 + 8 * w) chk(done_w == 1'b1 || av, "R4", "done pulse", done_w, 1);
        end
        insn_done = 1'b0; mask_wr = 1'b0;
        expt = av ? (40 + last_iack_as + 1) : (44 + 8 * w);
        chk(total == expt, av ? "R8" : (w != 0 ? "R6" : "R4"), "sequence clocks", total, expt);
        chk(mask_w == lvl, "R11", "mask after sequence", mask_w, lvl);
        chk(handler_w == hnd, "R10", "handler address", handler_w, hnd);
        chk(sb.size() == 0, "R5", "all 8 bus cycles seen", sb.size(), 0);
        mdl_mask = lvl;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(phase_w == 4'd0, "R1", "phase", phase_w, 0);
        chk(!as_w && !ds_w, "R1", "strobes", {as_w, ds_w}, 0);
        chk(mask_w == 3'd7, "R1", "mask", mask_w, 7);
        chk(done_w == 1'b0, "R1", "done", done_w, 0);

        // R2: level 5 masked by reset mask 7
        irq_level = 3'd5;
        boundary(); boundary();
        chk(phase_w == 4'd0, "R2", "level 5 under mask 7", phase_w, 0);
        irq_level = 3'd0;
        boundary();
        write_mask(3'd2);
        chk(mask_w == 3'd2, "R2", "mask write", mask_w, 2);
        mdl_mask = 3'd2;

        // R4 R7 R9 R10: vectored, zero wait
        take_irq(3'd3, 0, 1'b0, 8'h40);
        irq_level = 3'd0;

        // R2: lower and equal levels ignored
        irq_level = 3'd2;
        boundary(); boundary();
        chk(phase_w == 4'd0, "R2", "level below mask", phase_w, 0);
        irq_level = 3'd3;
        boundary(); boundary();
        chk(phase_w == 4'd0, "R2", "level equal to mask", phase_w, 0);
        irq_level = 3'd0;
        boundary();

        // R3: level gone before the second boundary disarms
        irq_level = 3'd6;
        boundary();
        irq_level = 3'd0;
        boundary();
        irq_level = 3'd6;
        boundary();
        chk(phase_w == 4'd0, "R3", "re-arm needed after drop", phase_w, 0);
        irq_level = 3'd0;
        boundary();

        // R6 R11: two wait states, mask writes during sequence ignored
        take_irq(3'd5, 2, 1'b0, 8'h52);
        irq_level = 3'd0;

        // R8: autovector through slow handshake
        take_irq(3'd6, 0, 1'b1, 8'h00);
        irq_level = 3'd0;

        // R12: level 7 taken on rise even under mask 7
        write_mask(3'd7);
        chk(mask_w == 3'd7, "R2", "mask write 7", mask_w, 7);
        mdl_mask = 3'd7;
        take_irq(3'd7, 1, 1'b0, 8'h77);
        boundary(); boundary(); boundary();
        chk(phase_w == 4'd0, "R12", "held level 7 not retaken", phase_w, 0);
        irq_level = 3'd0;
        @(negedge clk);
        take_irq(3'd7, 0, 1'b1, 8'h00);
        irq_level = 3'd0;

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule